// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the serial side of a small byte-addressed memory device. It takes the four SPI pins (clock, active-low select, active-low pause and data in), brings them into the system clock domain, and delivers whole bytes to a simple command port. SPI mode 0 is used: SI is taken on SCK rising edges and SO changes on SCK falling edges. The memory array, its write timing and its status register sit behind that command port and are not part of this block.

The first byte of each selected frame is an opcode. A recognised opcode produces a command pulse, after the address bytes if the command has them. Later bytes become write-data pulses or read-data requests. An unrecognised opcode makes the block deaf and its output silent until select is asserted again. An active-low pause input stops a transfer without losing its bit or byte position. The pause starts and ends only when that input changes while SCK is low.

SO is given as a data bit plus an output-enable, with no tri-state net. Select, clock, pause and data pass through `SYNC_STAGES` flip-flops. The system clock must therefore run several times faster than SCK.

Top module: `spi_mem_front`

## Requirements
- R1: Bytes on SI are assembled most significant bit first. Each data byte of a write-type command appears on `wr_data_o` with a one-cycle `wr_valid_o` pulse.
- R2: The first complete byte after select falls is decoded as an opcode, with this map from opcode to `cmd_kind_o`: 0x06→1, 0x04→2, 0x05→3, 0x01→4, 0x03→5, 0x02→6. For kinds 1 to 4, `cmd_valid_o` pulses once after the opcode byte.
- R3: Any other opcode value produces no command, write or read pulse. It keeps `so_oe_o` low and ignores SI until select falls again. The next frame then decodes normally.
- R4: While select is high, SI and SCK have no effect, `so_oe_o` is low, and the command port stays idle.
- R5: A pause begins only when the pause input falls while SCK is low. It ends only when the pause input rises while SCK is low. SCK edges during a pause do not move the bit or byte position. A fall of the pause input while SCK is high does not start a pause.
- R6: While paused, `so_oe_o` is low and SI is ignored.
- R7: Kinds 5 and 6 take an address of `ADDR_BYTES` bytes after the opcode, most significant byte first. The address is shown on `cmd_addr_o` in the same cycle as `cmd_valid_o`, after its last byte.
- R8: For kinds 3 and 5, `rd_req_o` pulses when the header completes and again after each later byte. `rd_data_i` is taken one cycle after each request and shifted out on SO most significant bit first. Its first bit is valid before the first SCK rise of that byte, and the following bits change on SCK falls. `so_oe_o` is high during those data bytes.
- R9: `xfer_end_o` pulses once when select rises after an accepted opcode, and does not pulse after a rejected one.
- R10: For kind 4, each byte after the opcode is delivered on the write-data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| cs_n_i | input | 1 | Active-low select |
| hold_n_i | input | 1 | Active-low pause |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out bit |
| so_oe_o | output | 1 | Output enable for SO |
| cmd_valid_o | output | 1 | Command header complete (one-cycle pulse) |
| cmd_kind_o | output | 3 | Decoded command kind |
| cmd_addr_o | output | 8*ADDR_BYTES | Command address |
| wr_valid_o | output | 1 | Write-data byte pulse |
| wr_data_o | output | 8 | Write-data byte |
| rd_req_o | output | 1 | Request for the next byte to send |
| rd_data_i | input | 8 | Byte to send, valid one cycle after the request |
| xfer_end_o | output | 1 | Frame with an accepted opcode has ended |

## Verification
On every cycle, the bound checker watches that the command port stays idle after a deselected cycle. It also checks that a rejected frame never completes a byte, that pauses begin only with SCK low, that the bit position is frozen and SO disabled while paused, and that a command pulse never carries the null kind. Only the directed scenarios can show the byte values themselves: the opcode map, the assembled address, the write data and the read bytes seen bit by bit on SO. They also show the recovery after a rejected opcode, and the case where the pause input falls with SCK high and no pause follows.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_WREN  = 3'd1,
    K_WRDI  = 3'd2,
    K_RDSR  = 3'd3,
    K_WRSR  = 3'd4,
    K_READ  = 3'd5,
    K_WRITE = 3'd6
  } cmd_kind_e;

  // Opcode byte to command kind; unknown codes map to K_NONE.
  function automatic cmd_kind_e decode_op(input logic [7:0] op);
    case (op)
      8'h06:   return K_WREN;
      8'h04:   return K_WRDI;
      8'h05:   return K_RDSR;
      8'h01:   return K_WRSR;
      8'h03:   return K_READ;
      8'h02:   return K_WRITE;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic kind_reads(input cmd_kind_e k);
    return (k == K_RDSR) || (k == K_READ);
  endfunction

  function automatic logic kind_takes_data(input cmd_kind_e k);
    return (k == K_WRSR) || (k == K_WRITE);
  endfunction

  function automatic logic kind_has_addr(input cmd_kind_e k);
    return (k == K_READ) || (k == K_WRITE);
  endfunction

  // Header length in bytes: opcode plus address bytes when present.
  function automatic logic [3:0] hdr_len(input cmd_kind_e k, input logic [3:0] nab);
    return kind_has_addr(k) ? (4'd1 + nab) : 4'd1;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_front_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              hold_n_s,
  input  logic              si_s,
  input  logic              lock_i,
  input  logic              tx_on_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sel_o,
  output logic              cs_fall_o,
  output logic              cs_rise_o,
  output logic              paused_o,
  output logic [2:0]        bitcnt_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              so_o,
  output logic              so_oe_o
);

  logic sck_q, cs_q, hold_q;
  logic sck_rise, sck_fall;
  logic pause_enter, pause_leave;
  logic live, shift_in, shift_out;
  logic paused;
  logic [2:0] bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      hold_q <= 1'b1;
    end else begin
      sck_q  <= sck_s;
      cs_q   <= cs_n_s;
      hold_q <= hold_n_s;
    end

  assign sel_o     = ~cs_n_s;
  assign cs_fall_o = cs_q & ~cs_n_s;
  assign cs_rise_o = ~cs_q & cs_n_s;
  assign sck_rise  = sck_s & ~sck_q;
  assign sck_fall  = ~sck_s & sck_q;

  // Pause edges count only while SCK is low.
  assign pause_enter = sel_o & hold_q & ~hold_n_s & ~sck_s;
  assign pause_leave = sel_o & ~hold_q & hold_n_s & ~sck_s;

  assign live      = sel_o & ~paused & ~lock_i;
  assign shift_in  = live & sck_rise;
  assign shift_out = live & sck_fall & (bitcnt != 3'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           paused <= 1'b0;
    else if (!sel_o)      paused <= 1'b0;
    else if (pause_enter) paused <= 1'b1;
    else if (pause_leave) paused <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt      <= 3'd0;
      rx_sh       <= '0;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
    end else begin
      byte_done_o <= 1'b0;
      if (!sel_o) begin
        bitcnt <= 3'd0;
      end else if (shift_in) begin
        bitcnt <= bitcnt + 3'd1;
        rx_sh  <= {rx_sh[BYTE_W-2:0], si_s};
        if (bitcnt == 3'd7) begin
          byte_done_o <= 1'b1;
          rx_byte_o   <= {rx_sh[BYTE_W-2:0], si_s};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         tx_sh <= '0;
    else if (tx_load_i) tx_sh <= tx_byte_i;
    else if (shift_out) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};

  assign paused_o = paused;
  assign bitcnt_o = bitcnt;
  assign so_o     = tx_sh[BYTE_W-1];
  assign so_oe_o  = live & tx_on_i;

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_front_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              lock_o,
  output logic              tx_on_o,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic              xfer_end_o
);

  localparam logic [3:0] NAB = 4'(ADDR_BYTES);

  cmd_kind_e   kind, kind_now;
  logic [3:0]  byte_idx, hdr;
  logic        in_hdr, last_hdr;
  logic        locked, started, reading, rd_pend;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    kind_now = (byte_idx == 4'd0) ? decode_op(rx_byte_i) : kind;
    hdr      = hdr_len(kind_now, NAB);
    in_hdr   = byte_idx < hdr;
    last_hdr = byte_idx == (hdr - 4'd1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kind        <= K_NONE;
      byte_idx    <= 4'd0;
      locked      <= 1'b0;
      started     <= 1'b0;
      reading     <= 1'b0;
      rd_pend     <= 1'b0;
      addr        <= '0;
      cmd_valid_o <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_data_o   <= '0;
      rd_req_o    <= 1'b0;
      xfer_end_o  <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      wr_valid_o  <= 1'b0;
      rd_req_o    <= 1'b0;
      xfer_end_o  <= 1'b0;
      rd_pend     <= rd_req_o;
      if (cs_fall_i) locked <= 1'b0;
      if (cs_rise_i && started) begin
        xfer_end_o <= 1'b1;
        started    <= 1'b0;
      end
      if (!sel_i) begin
        byte_idx <= 4'd0;
        reading  <= 1'b0;
      end else if (byte_done_i && !locked) begin
        if (byte_idx == 4'd0 && kind_now == K_NONE) begin
          locked <= 1'b1;
        end else begin
          if (byte_idx == 4'd0) begin
            kind    <= kind_now;
            started <= 1'b1;
            addr    <= '0;
          end else if (in_hdr) begin
            addr <= (addr << 8) | ADDR_W'(rx_byte_i);
          end
          if (in_hdr && last_hdr) begin
            cmd_valid_o <= 1'b1;
            if (kind_reads(kind_now)) begin
              rd_req_o <= 1'b1;
              reading  <= 1'b1;
            end
          end
          if (!in_hdr) begin
            if (kind_takes_data(kind_now)) begin
              wr_valid_o <= 1'b1;
              wr_data_o  <= rx_byte_i;
            end
            if (reading) rd_req_o <= 1'b1;
          end
          if (in_hdr) byte_idx <= byte_idx + 4'd1;
        end
      end
    end

  assign lock_o     = locked;
  assign tx_on_o    = reading;
  assign tx_load_o  = rd_pend;
  assign tx_byte_o  = rd_data_i;
  assign cmd_kind_o = kind;
  assign cmd_addr_o = addr;

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_front_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BYTES  = 2,
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_req_o,
  input  logic [7:0]        rd_data_i,
  output logic              xfer_end_o
);

  logic [3:0] pins_s;
  logic sck_s, cs_n_s, hold_n_s, si_s;
  logic sel, cs_fall, cs_rise, paused, byte_done, locked;
  logic tx_on, tx_load;
  logic [2:0] bitcnt;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  spi_in_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0110)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({si_i, hold_n_i, cs_n_i, sck_i}),
    .q_o  (pins_s)
  );

  assign sck_s    = pins_s[0];
  assign cs_n_s   = pins_s[1];
  assign hold_n_s = pins_s[2];
  assign si_s     = pins_s[3];

  spi_bit_engine u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (sck_s),
    .cs_n_s     (cs_n_s),
    .hold_n_s   (hold_n_s),
    .si_s       (si_s),
    .lock_i     (locked),
    .tx_on_i    (tx_on),
    .tx_load_i  (tx_load),
    .tx_byte_i  (tx_byte),
    .sel_o      (sel),
    .cs_fall_o  (cs_fall),
    .cs_rise_o  (cs_rise),
    .paused_o   (paused),
    .bitcnt_o   (bitcnt),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  spi_cmd_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .rd_data_i  (rd_data_i),
    .lock_o     (locked),
    .tx_on_o    (tx_on),
    .tx_load_o  (tx_load),
    .tx_byte_o  (tx_byte),
    .cmd_valid_o(cmd_valid_o),
    .cmd_kind_o (cmd_kind_o),
    .cmd_addr_o (cmd_addr_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .rd_req_o   (rd_req_o),
    .xfer_end_o (xfer_end_o)
  );

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       sck_s,
  input logic       paused,
  input logic       locked,
  input logic [2:0] bitcnt,
  input logic       byte_done,
  input logic       so_oe_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_kind_o,
  input logic       wr_valid_o,
  input logic       rd_req_o
);

  // R4: a deselected cycle is never followed by command port activity.
  p_idle_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel) |-> !cmd_valid_o && !wr_valid_o && !rd_req_o);

  // R3: a rejected frame completes no further byte and issues no command.
  p_locked_deaf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !byte_done && !cmd_valid_o && !wr_valid_o);

  // R5: a pause only starts from an SCK-low moment.
  p_pause_entry_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(!sck_s));

  // R5: bit position frozen while the pause lasts.
  p_pause_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    paused && $past(paused) |-> $stable(bitcnt));

  // R6: no completed byte and no output drive during a pause.
  p_pause_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    paused && $past(paused) |-> !so_oe_o && !byte_done);

  // R2: a command pulse always carries a decoded kind.
  p_kind_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_kind_o != 3'd0 && cmd_kind_o != 3'd7);

endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .sck_s      (sck_s),
  .paused     (paused),
  .locked     (locked),
  .bitcnt     (bitcnt),
  .byte_done  (byte_done),
  .so_oe_o    (so_oe_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_kind_o (cmd_kind_o),
  .wr_valid_o (wr_valid_o),
  .rd_req_o   (rd_req_o)
);

// File: tb/tb_spi_mem_front.sv
module tb_spi_mem_front;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic so, so_oe, cmd_valid, wr_valid, rd_req, xfer_end;
  logic [2:0]  cmd_kind;
  logic [15:0] cmd_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data = 8'h00;

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0, n_wr = 0, n_end = 0, rd_idx = 0;
  logic [2:0]  last_kind;
  logic [15:0] last_addr;
  logic [7:0]  wr_log [16];

  always #5 clk = ~clk;

  spi_mem_front dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .si_i(si), .so_o(so), .so_oe_o(so_oe), .cmd_valid_o(cmd_valid),
    .cmd_kind_o(cmd_kind), .cmd_addr_o(cmd_addr), .wr_valid_o(wr_valid),
    .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_data_i(rd_data),
    .xfer_end_o(xfer_end)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'h5A ^ 8'(i * 59);
  endfunction

  // Memory side: answers each request one cycle later.
  always @(posedge clk) if (rd_req) begin
    rd_data <= pat(rd_idx);
    rd_idx  <= rd_idx + 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin n_cmd++; last_kind = cmd_kind; last_addr = cmd_addr; end
    if (wr_valid) begin wr_log[n_wr % 16] = wr_data; n_wr++; end
    if (xfer_end) n_end++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select();
    @(negedge clk) cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic deselect();
    @(negedge clk) cs_n = 1'b1; wait_clk(HALF);
  endtask

  // mode 0: plain; 1: pause with SCK low before bit `at`; 2: pause pin falls
  // while SCK is high at bit `at` and rises with SCK low at byte end.
  task automatic xbyte(input logic [7:0] tx, input int mode, input int at,
                       output logic [7:0] rx, output logic oe_all, output logic oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) si = tx[i];
      if (mode == 1 && i == at) begin
        hold_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < 4; k++) begin
          si = ~si; sck = 1'b1; wait_clk(HALF);
          chk("R6 oe during pause", so_oe, 0);
          sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1; wait_clk(HALF);
        si = tx[i];
      end
      wait_clk(HALF - 1);
      rx[i] = so;
      oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1; wait_clk(3);
      if (mode == 2 && i == at) hold_n = 1'b0;
      wait_clk(HALF - 3);
      sck = 1'b0;
    end
    if (mode == 2) begin wait_clk(2); hold_n = 1'b1; end
    wait_clk(HALF);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; logic a, b;
    xbyte(tx, 0, 0, r, a, b);
  endtask

  task automatic t_reset();
    chk("R4 reset oe", so_oe, 0);
    chk("R4 reset cmd", {cmd_valid, wr_valid, rd_req, xfer_end}, 0);
  endtask

  task automatic t_wren();
    int c0 = n_cmd, e0 = n_end, w0 = n_wr;
    select(); send(8'h06); wait_clk(4);
    chk("R2 wren count", n_cmd - c0, 1);
    chk("R2 wren kind", last_kind, 1);
    chk("R10 wren no data", n_wr - w0, 0);
    deselect();
    chk("R9 end pulse", n_end - e0, 1);
    select(); send(8'h04); deselect();
    chk("R2 wrdi kind", last_kind, 2);
  endtask

  task automatic t_write(input int mode, input int at, input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1, input string req);
    int c0 = n_cmd, w0 = n_wr;
    logic [7:0] r; logic oa, ob;
    select(); send(8'h02);
    xbyte(a[15:8], mode, at, r, oa, ob);
    send(a[7:0]); send(d0); send(d1); deselect();
    chk({req, " write cmd"}, n_cmd - c0, 1);
    chk("R2 write kind", last_kind, 6);
    chk("R7 write addr", last_addr, a);
    chk("R1 write count", n_wr - w0, 2);
    chk("R1 data0", wr_log[w0 % 16], d0);
    chk("R1 data1", wr_log[(w0 + 1) % 16], d1);
  endtask

  task automatic t_read(input logic [7:0] op, input int nbytes, input int pause_byte);
    int base = rd_idx, c0 = n_cmd;
    logic [7:0] r; logic oa, ob;
    select(); send(op);
    if (op == 8'h03) begin send(8'hBE); send(8'hEF); end
    for (int b = 0; b < nbytes; b++) begin
      xbyte(8'h00, (b == pause_byte) ? 1 : 0, 4, r, oa, ob);
      chk("R8 read byte", r, pat(base + b));
      chk("R8 oe in data", oa, 1);
    end
    deselect();
    chk("R2 read cmd", n_cmd - c0, 1);
    chk("R2 read kind", last_kind, (op == 8'h03) ? 5 : 3);
    if (op == 8'h03) chk("R7 read addr", last_addr, 16'hBEEF);
    chk("R8 req count", rd_idx - base, nbytes + 1);
  endtask

  task automatic t_wrsr();
    int w0 = n_wr;
    select(); send(8'h01); send(8'h8C); deselect();
    chk("R2 wrsr kind", last_kind, 4);
    chk("R10 wrsr data", wr_log[w0 % 16], 8'h8C);
  endtask

  task automatic t_invalid();
    int c0 = n_cmd, w0 = n_wr, e0 = n_end, q0 = rd_idx;
    logic [7:0] r; logic oa, ob, any_oe = 1'b0;
    select();
    xbyte(8'hFF, 0, 0, r, oa, ob); any_oe |= ob;
    xbyte(8'h03, 0, 0, r, oa, ob); any_oe |= ob;
    xbyte(8'h00, 0, 0, r, oa, ob); any_oe |= ob;
    xbyte(8'h02, 0, 0, r, oa, ob); any_oe |= ob;
    deselect();
    chk("R3 no cmd", n_cmd - c0, 0);
    chk("R3 no data", n_wr - w0, 0);
    chk("R3 no req", rd_idx - q0, 0);
    chk("R3 oe low", any_oe, 0);
    chk("R9 no end after reject", n_end - e0, 0);
    select(); send(8'h04); deselect();
    chk("R3 recovery cmd", n_cmd - c0, 1);
    chk("R3 recovery kind", last_kind, 2);
  endtask

  task automatic t_deselected();
    int c0 = n_cmd, w0 = n_wr;
    logic [7:0] r; logic oa, ob, any_oe = 1'b0;
    xbyte(8'h06, 0, 0, r, oa, ob); any_oe |= ob;
    xbyte(8'h02, 0, 0, r, oa, ob); any_oe |= ob;
    chk("R4 no cmd deselected", n_cmd - c0 + n_wr - w0, 0);
    chk("R4 oe deselected", any_oe, 0);
    select(); send(8'h01); send(8'h33); deselect();
    chk("R4 first byte after select", last_kind, 4);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_wren();
    t_write(0, 0, 16'h1234, 8'hA5, 8'h3C, "R1");
    t_read(8'h03, 3, -1);
    t_read(8'h05, 2, -1);
    t_wrsr();
    t_invalid();
    t_deselected();
    t_write(1, 3, 16'hC3A7, 8'h96, 8'h0F, "R5 pause");
    t_write(2, 5, 16'h5B21, 8'h44, 8'hE1, "R5 high-sck fall");
    t_read(8'h03, 2, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule